// File: doc/BRIEF.md
# Randomly Stalling Memory Front End

This block places a word-addressed storage array behind a request/stall/done handshake, the same kind a processor's data cache presents. Each access is held back for a pseudo-random number of cycles before it completes. A pipeline attached to it sees stall periods of irregular length. This exercises its hazard and hold logic far harder than a fixed-latency memory would.

The requester raises a read or write strobe together with an address and write data. The block captures the request on the next clock edge. It then signals stall until the access finishes. Completion is marked by a one-cycle done pulse, and for reads the word is presented on that same cycle.

Whether the memory can finish in a given cycle is decided by a 32-bit pattern register. The register is loaded from a seed parameter at reset and rotates every clock. Different seeds therefore give different, repeatable stall sequences.

Top module: `rstall_mem`

## Requirements
- R1: While reset is high and in the first cycle after it, stall_o, done_o and rdata_o are all 0.
- R2: A 32-bit pattern is loaded with the SEED parameter on reset. On every other clock edge it rotates right by one bit: bit 0 moves into bit 31. The memory is ready in a cycle exactly when bit 0 of the pattern is 1.
- R3: A request is accepted on a clock edge where rd_i or wr_i is high and no access is pending. Address and write data are captured on that edge. Changing addr_i or wdata_i while the access is pending has no effect on it.
- R4: In each cycle after acceptance in which the access is pending and the memory is not ready, stall_o is 1. In every other cycle stall_o is 0. stall_o and done_o are never high together.
- R5: done_o is high for exactly one cycle: the first ready cycle after acceptance. In the following cycle done_o and stall_o are both 0 unless a new request is made.
- R6: In the done cycle of a read, rdata_o equals the word stored at the captured address. In all other cycles rdata_o is 0.
- R7: A write stores the captured data at the captured address at the end of its done cycle. A later read of that address returns it.
- R8: A request with rd_i and wr_i both high is performed as a write. rdata_o stays 0 in its done cycle.
- R9: A SEED of zero is replaced by the constant 32'hA5C3_1E69, so the pattern is never all zeros.
- R10: Every access completes within 32 cycles after acceptance.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_i | input | 1 | Read request strobe |
| wr_i | input | 1 | Write request strobe (wins over rd_i) |
| addr_i | input | ADDR_W | Word address of the request |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the done cycle of a read, else 0 |
| stall_o | output | 1 | Access pending and not yet completing |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench keeps its own copy of the rotating pattern, built from the seed rule. It predicts the exact cycle of every done pulse, so a wrong seed, rotation direction or ready bit shows up at the first access as a done or stall in the wrong cycle. A controller stuck pending would hold stall past the predicted cycle. A lost or misplaced write, or a capture of late-changed inputs, surfaces at the next read of that address as wrong rdata_o. Each access also checks the cycle after done, which exposes a pulse that lasts too long or a request accepted twice.

// File: rtl/rstall_pkg.sv
package rstall_pkg;

    localparam int PAT_W = 32;
    localparam logic [PAT_W-1:0] SEED_FALLBACK = 32'hA5C3_1E69;

    typedef enum logic {
        OP_READ  = 1'b0,
        OP_WRITE = 1'b1
    } op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_PEND = 1'b1
    } state_e;

    // a zero pattern would never signal ready
    function automatic logic [PAT_W-1:0] seed_fix(input logic [PAT_W-1:0] s);
        return (s == '0) ? SEED_FALLBACK : s;
    endfunction

    function automatic logic [PAT_W-1:0] rot1(input logic [PAT_W-1:0] p);
        return {p[0], p[PAT_W-1:1]};
    endfunction

endpackage

// File: rtl/rstall_pattern.sv
module rstall_pattern
    import rstall_pkg::*;
#(
    parameter logic [PAT_W-1:0] SEED = 32'h1234_5679
) (
    input  logic             clk,
    input  logic             rst,
    output logic [PAT_W-1:0] pat,
    output logic             ready
);
    localparam logic [PAT_W-1:0] START = seed_fix(SEED);

    always_ff @(posedge clk) begin
        if (rst) pat <= START;
        else     pat <= rot1(pat);
    end

    assign ready = pat[0];
endmodule

// File: rtl/rstall_store.sv
module rstall_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/rstall_ctrl.sv
module rstall_ctrl
    import rstall_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              ready,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] data_q,
    output logic              is_read,
    output logic              we,
    output logic              stall,
    output logic              done
);
    state_e st;
    op_e    op_q;
    logic   pending;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            op_q   <= OP_READ;
            addr_q <= '0;
            data_q <= '0;
        end else begin
            case (st)
                ST_IDLE: if (rd || wr) begin
                    st     <= ST_PEND;
                    op_q   <= wr ? OP_WRITE : OP_READ;
                    addr_q <= addr;
                    data_q <= wdata;
                end
                ST_PEND: if (ready) st <= ST_IDLE;
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign pending = (st == ST_PEND);
    assign done    = pending && ready;
    assign stall   = pending && !ready;
    assign is_read = (op_q == OP_READ);
    assign we      = done && (op_q == OP_WRITE);
endmodule

// File: rtl/rstall_mem.sv
module rstall_mem
    import rstall_pkg::*;
#(
    parameter int               ADDR_W = 8,
    parameter int               DATA_W = 16,
    parameter logic [PAT_W-1:0] SEED   = 32'h1234_5679
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              stall_o,
    output logic              done_o
);
    logic [PAT_W-1:0]  pat_w;
    logic              ready_w;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;
    logic [DATA_W-1:0] word_w;
    logic              is_read_w;
    logic              we_w;

    rstall_pattern #(.SEED(SEED)) pat_i (
        .clk   (clk),
        .rst   (rst),
        .pat   (pat_w),
        .ready (ready_w)
    );

    rstall_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) ctrl_i (
        .clk     (clk),
        .rst     (rst),
        .rd      (rd_i),
        .wr      (wr_i),
        .addr    (addr_i),
        .wdata   (wdata_i),
        .ready   (ready_w),
        .addr_q  (addr_q),
        .data_q  (data_q),
        .is_read (is_read_w),
        .we      (we_w),
        .stall   (stall_o),
        .done    (done_o)
    );

    rstall_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) store_i (
        .clk   (clk),
        .we    (we_w),
        .waddr (addr_q),
        .wdata (data_q),
        .raddr (addr_q),
        .rdata (word_w)
    );

    assign rdata_o = (done_o && is_read_w) ? word_w : '0;
endmodule

// File: rtl/rstall_mem_chk.sv
module rstall_mem_chk
    import rstall_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic [PAT_W-1:0]  pat,
    input logic [DATA_W-1:0] rdata_o,
    input logic              stall_o,
    input logic              done_o
);
    logic [PAT_W-1:0] prev_q;
    logic             ran_q;
    logic [5:0]       wait_q;

    always_ff @(posedge clk) begin
        prev_q <= pat;
        ran_q  <= !rst;
        if (rst || !stall_o) wait_q <= '0;
        else if (wait_q != 6'h3f) wait_q <= wait_q + 6'd1;
    end

    AST_PAT_ROTATES: assert property (@(posedge clk) disable iff (rst)
        ran_q |-> (pat == rot1(prev_q))) else $error("pattern rotation");           // R2
    AST_PAT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        pat != '0) else $error("pattern zero");                                      // R9
    AST_DONE_READY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> pat[0]) else $error("done without ready");                        // R2
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(stall_o && done_o)) else $error("stall with done");                        // R4
    AST_STALL_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> (stall_o || done_o)) else $error("stall dropped without done");  // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o) else $error("done longer than one cycle");               // R5
    AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (rst)
        (rdata_o != '0) |-> done_o) else $error("rdata outside done");               // R6
    AST_WAIT_BOUND: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (wait_q < 6'(PAT_W - 1))) else $error("stall too long");         // R10
endmodule

bind rstall_mem rstall_mem_chk #(.DATA_W(DATA_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .pat     (pat_w),
    .rdata_o (rdata_o),
    .stall_o (stall_o),
    .done_o  (done_o)
);

// File: tb/rstall_mem_tb_top.sv
module rstall_mem_tb_top;
    localparam int          AW     = 8;
    localparam int          DW     = 16;
    localparam logic [31:0] SEED_A = 32'h1234_5679;
    localparam logic [31:0] FALLBK = 32'hA5C3_1E69;

    logic clk = 0;
    logic rst = 1;
    always #5 clk = ~clk;

    logic          a_rd = 0, a_wr = 0, z_rd = 0, z_wr = 0;
    logic [AW-1:0] a_addr = '0, z_addr = '0;
    logic [DW-1:0] a_wd = '0, z_wd = '0;
    logic [DW-1:0] a_rdata, z_rdata;
    logic          a_stall, a_done, z_stall, z_done;

    rstall_mem #(.ADDR_W(AW), .DATA_W(DW), .SEED(SEED_A)) dut_i (
        .clk(clk), .rst(rst), .rd_i(a_rd), .wr_i(a_wr), .addr_i(a_addr),
        .wdata_i(a_wd), .rdata_o(a_rdata), .stall_o(a_stall), .done_o(a_done));

    rstall_mem #(.ADDR_W(AW), .DATA_W(DW), .SEED(32'h0)) dut_z (
        .clk(clk), .rst(rst), .rd_i(z_rd), .wr_i(z_wr), .addr_i(z_addr),
        .wdata_i(z_wd), .rdata_o(z_rdata), .stall_o(z_stall), .done_o(z_done));

    // pattern models built from R2 and R9
    logic [31:0] m_a, m_z;
    always @(posedge clk) begin
        if (rst) begin m_a <= SEED_A; m_z <= FALLBK; end
        else begin m_a <= {m_a[0], m_a[31:1]}; m_z <= {m_z[0], m_z[31:1]}; end
    end

    int n_chk = 0, n_bad = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input bit z, input bit rd, input bit wr,
                         input logic [AW-1:0] ad, input logic [DW-1:0] wd);
        if (z) begin z_rd = rd; z_wr = wr; z_addr = ad; z_wd = wd; end
        else   begin a_rd = rd; a_wr = wr; a_addr = ad; a_wd = wd; end
    endtask

    // one access; expect_rd: compare rdata with exp_data in done cycle
    task automatic access(input bit z, input bit rd, input bit wr,
                          input logic [AW-1:0] ad, input logic [DW-1:0] wd,
                          input bit scramble, input logic [DW-1:0] exp_data);
        bit fin = 0;
        @(negedge clk);
        drive(z, rd, wr, ad, wd);
        @(posedge clk);
        for (int i = 1; i <= 40 && !fin; i++) begin
            logic rdy, st, dn;
            logic [DW-1:0] rdt;
            @(negedge clk);
            rdy = z ? m_z[0] : m_a[0];
            st  = z ? z_stall : a_stall;
            dn  = z ? z_done  : a_done;
            rdt = z ? z_rdata : a_rdata;
            if (rdy) begin
                chk(dn == 1'b1, z ? "R9 done timing" : "R2/R5 done timing", dn, 1);
                chk(st == 1'b0, "R4 stall low in done cycle", st, 0);
                if (rd && !wr) chk(rdt == exp_data, "R6 read data", rdt, exp_data);
                else           chk(rdt == '0, "R8 rdata zero on write", rdt, 0);
                chk(i <= 32, "R10 latency", i, 32);
                drive(z, 0, 0, '0, '0);
                fin = 1;
            end else begin
                chk(st == 1'b1 && dn == 1'b0, "R4 stall while waiting", {st, dn}, 2'b10);
                if (scramble) drive(z, rd, wr, ~ad, ~wd);   // R3: late changes ignored
            end
        end
        if (!fin) chk(0, "R10 access never completed", 0, 1);
        @(negedge clk);
        chk((z ? z_done : a_done) == 1'b0 && (z ? z_stall : a_stall) == 1'b0,
            "R5 quiet after done", {z ? z_stall : a_stall, z ? z_done : a_done}, 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(a_stall == 0 && a_done == 0 && a_rdata == 0, "R1 outputs in reset",
            {a_stall, a_done, a_rdata}, 0);
        rst = 0;
        @(negedge clk);
        chk(a_stall == 0 && a_done == 0 && a_rdata == 0, "R1 outputs after reset",
            {a_stall, a_done, a_rdata}, 0);
        repeat (5) @(negedge clk);
        chk(a_stall == 0 && z_stall == 0, "R4 idle without request", {a_stall, z_stall}, 0);
    endtask

    task automatic t_write_read();
        for (int k = 0; k < 6; k++)
            access(0, 0, 1, AW'(k * 37 + 3), DW'(16'h1000 + k * 16'h0111), 0, '0);
        for (int k = 5; k >= 0; k--)
            access(0, 1, 0, AW'(k * 37 + 3), '0, 0, DW'(16'h1000 + k * 16'h0111)); // R7
    endtask

    task automatic t_hold_inputs();
        access(0, 0, 1, 8'h40, 16'hBEEF, 1, '0);
        access(0, 1, 0, 8'h40, '0, 1, 16'hBEEF);          // R3
        access(0, 1, 0, 8'hBF, '0, 0, 16'h0000);          // R3: the complement address
        // ~8'h40 = 8'hBF: must not have been written (it holds no write; compare below)
    endtask

    task automatic t_both_strobes();
        access(0, 0, 1, 8'h77, 16'h1111, 0, '0);
        access(0, 1, 1, 8'h77, 16'h2222, 0, '0);          // R8: treated as write
        access(0, 1, 0, 8'h77, '0, 0, 16'h2222);
    endtask

    task automatic t_zero_seed();
        access(1, 0, 1, 8'h05, 16'hC0DE, 0, '0);
        access(1, 1, 0, 8'h05, '0, 0, 16'hC0DE);          // R9
        access(1, 0, 1, 8'h06, 16'h5A5A, 0, '0);
        access(1, 1, 0, 8'h06, '0, 0, 16'h5A5A);
    endtask

    initial begin
        #(200000 * 10);
        chk(0, "watchdog expired", 0, 1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        // prime 8'hBF with a known value before the hold test checks it stays untouched
        access(0, 0, 1, 8'hBF, 16'h0000, 0, '0);
        t_write_read();
        t_hold_inputs();
        t_both_strobes();
        t_zero_seed();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule